// File: doc/BRIEF.md
# SKP Ordered-Set Rate-Match FIFO

This block sits in the receive path of one lane of an 8b/10b serial link, after symbol decoding. It takes decoded bytes, each with a control flag and a valid strobe, in the clock recovered from the line. It delivers them in the local clock domain. The far transmitter and the local reference may drift apart by up to 300 ppm each way, 600 ppm in all. The FIFO absorbs that drift by adjusting only the skip symbols inside skip ordered sets, which appear in the idle gaps between packets. A set is a comma symbol followed by skip symbols. The far end sends three skips per set, and any count from one to five is legal on receive.

When the FIFO runs too full, the write side drops a skip from a set that has already stored one. When it runs too empty, the read side repeats a skip at the end of a set, as long as the set stays within five. The comma, stray skips and every other byte pass unchanged and in order. On the local side the block flags each inserted or removed skip and each malformed set. It also keeps sticky overflow and underflow flags.

Top module: `skp_rate_match`

## Requirements
- R1: Every byte that is not a skip inside a set leaves on the local side in arrival order with its data and control flag unchanged. The pointers cross between the clocks as Gray code, changing at most one bit per cycle.
- R2: The comma is control flag 1 with byte 0xBC, and a skip is control flag 1 with byte 0x1C. A skip counts as part of a set only when it directly follows a comma or a set skip. Stray skips, and byte 0x1C with control flag 0, are never removed or counted.
- R3: A set skip is removed on the write side only under three conditions: the write-side fill is above HI_MARK (12), the set has already stored at least one skip, and the previous arriving byte was not removed. The delete pulse is raised with the output byte that followed the removed skip.
- R4: A skip is inserted on the read side only under four conditions: the read-side fill is above 0 and below LO_MARK (4), the last byte sent out was a set skip, the next stored byte is not a skip, and the set holds at most five skips after insertion. The insert pulse is raised with the inserted skip.
- R5: For every set, the skips sent out plus the deletions minus the insertions equal the skips received. A set received with one to five skips leaves with one to five.
- R6: A one-cycle malformed pulse is raised in two cases. It comes with the output byte that closes a set holding no skip, and it comes with the sixth skip of a set.
- R7: When 16 entries are held on the write side, an arriving byte is dropped and the sticky `rx_overflow` is set. Only reset clears it.
- R8: Reading starts once PRIME_LVL (8) entries are visible. If the FIFO runs empty after that, the sticky `lc_underflow` is set and reading waits for the FIFO to prime again. Only reset clears the flag.
- R9: Insert and delete pulses never occur in the same cycle. Every pulse comes with a valid output byte.
- R10: After reset, the output valid, all pulses and both sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered clock |
| rx_rst | input | 1 | Synchronous active-high reset, recovered domain |
| rx_valid | input | 1 | Input byte strobe |
| rx_ctl | input | 1 | Input control flag |
| rx_data | input | 8 | Input byte |
| rx_overflow | output | 1 | Sticky overflow flag, recovered domain |
| lc_clk | input | 1 | Local clock |
| lc_rst | input | 1 | Synchronous active-high reset, local domain |
| lc_valid | output | 1 | Output byte strobe |
| lc_ctl | output | 1 | Output control flag |
| lc_data | output | 8 | Output byte |
| lc_skp_ins | output | 1 | Pulse: this output byte is an inserted skip |
| lc_skp_del | output | 1 | Pulse: a skip before this output byte was removed |
| lc_bad_set | output | 1 | Pulse: malformed set detected at this byte |
| lc_underflow | output | 1 | Sticky underflow flag, local domain |

## Verification
A removal and a malformed-set report can land on the same output byte. This happens when a set of seven or eight skips arrives while the FIFO is above its high mark: one skip is dropped, and the skip that follows it becomes the sixth one sent out. The bench provokes this by mixing long sets into a recovered clock that runs faster than the local one. It judges each pulse on its own. The malformed pulse is recomputed from the output stream alone. Each delete is checked against the set's skip count so far. The per-set balance of received skips, sent skips and pulses then confirms that each pulse stood for exactly one edit.

// File: rtl/rmf_pkg.sv
package rmf_pkg;

    localparam logic [7:0] SYM_COM = 8'hBC;
    localparam logic [7:0] SYM_SKP = 8'h1C;
    localparam int         GRAY_W  = 16;

    typedef struct packed {
        logic       del_mark;
        logic       ctl;
        logic [7:0] data;
    } rmf_word_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_STORE,
        SRC_FILL
    } rmf_src_e;

    function automatic logic sym_is_com(input logic ctl, input logic [7:0] data);
        return ctl && (data == SYM_COM);
    endfunction

    function automatic logic sym_is_skp(input logic ctl, input logic [7:0] data);
        return ctl && (data == SYM_SKP);
    endfunction

    function automatic logic [GRAY_W-1:0] bin_to_gray(input logic [GRAY_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_W-1:0] gray_to_bin(input logic [GRAY_W-1:0] g);
        logic [GRAY_W-1:0] b;
        b[GRAY_W-1] = g[GRAY_W-1];
        for (int i = GRAY_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/rmf_sync.sv
module rmf_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe[i] <= '0;
            end
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/rmf_store.sv
module rmf_store
    import rmf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  rmf_word_t         wdata,
    input  logic [ADDR_W-1:0] raddr,
    output rmf_word_t         rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    rmf_word_t mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rmf_wr_ctl.sv
module rmf_wr_ctl
    import rmf_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int HI_MARK = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_ctl,
    input  logic [7:0]        in_data,
    input  logic [ADDR_W:0]   rd_gray_s,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output rmf_word_t         wdata,
    output logic [ADDR_W:0]   wr_gray,
    output logic              overflow
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PTR_W-1:0] wr_bin, wr_bin_nx, rd_bin_s, fill;
    logic             in_set, seen_skp, pend_del;
    logic             is_com, is_skp;
    logic             do_del, accept, full, do_write, drop;

    assign rd_bin_s = PTR_W'(gray_to_bin(GRAY_W'(rd_gray_s)));
    assign fill     = wr_bin - rd_bin_s;
    assign full     = (fill == PTR_W'(DEPTH));

    assign is_com   = sym_is_com(in_ctl, in_data);
    assign is_skp   = sym_is_skp(in_ctl, in_data);

    // removal keeps at least one stored skip and never removes two in a row
    assign do_del   = in_valid && is_skp && in_set && seen_skp && !pend_del
                      && (fill > PTR_W'(HI_MARK));
    assign accept   = in_valid && !do_del;
    assign do_write = accept && !full;
    assign drop     = accept && full;
    assign wr_bin_nx = wr_bin + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin   <= '0;
            wr_gray  <= '0;
            overflow <= 1'b0;
            in_set   <= 1'b0;
            seen_skp <= 1'b0;
            pend_del <= 1'b0;
        end else begin
            if (do_write) begin
                wr_bin  <= wr_bin_nx;
                wr_gray <= PTR_W'(bin_to_gray(GRAY_W'(wr_bin_nx)));
            end
            if (drop) begin
                overflow <= 1'b1;
            end
            if (do_del) begin
                pend_del <= 1'b1;
            end else if (do_write) begin
                pend_del <= 1'b0;
            end
            if (in_valid) begin
                if (is_com) begin
                    in_set   <= 1'b1;
                    seen_skp <= 1'b0;
                end else if (is_skp && in_set) begin
                    seen_skp <= seen_skp | do_write;
                end else begin
                    in_set   <= 1'b0;
                    seen_skp <= 1'b0;
                end
            end
        end
    end

    assign we    = do_write;
    assign waddr = wr_bin[ADDR_W-1:0];

    always_comb begin
        wdata          = '0;
        wdata.del_mark = pend_del;
        wdata.ctl      = in_ctl;
        wdata.data     = in_data;
    end

endmodule

// File: rtl/rmf_rd_ctl.sv
module rmf_rd_ctl
    import rmf_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int LO_MARK   = 4,
    parameter int PRIME_LVL = 8,
    parameter int MAX_SKP   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W:0]   wr_gray_s,
    output logic [ADDR_W-1:0] raddr,
    input  rmf_word_t         head,
    output logic [ADDR_W:0]   rd_gray,
    output logic              out_valid,
    output logic              out_ctl,
    output logic [7:0]        out_data,
    output logic              out_ins,
    output logic              out_del,
    output logic              out_bad,
    output logic              underflow
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int CNT_W = 3;

    logic [PTR_W-1:0] rd_bin, rd_bin_nx, wr_bin_s, fill;
    logic             primed, avail;
    logic             in_set, last_set_skp;
    logic [CNT_W-1:0] skp_cnt;
    logic             head_skp;
    rmf_src_e         src;
    logic             sel_ctl;
    logic [7:0]       sel_data;
    logic             sel_skp, sel_com, sel_bad;

    assign wr_bin_s  = PTR_W'(gray_to_bin(GRAY_W'(wr_gray_s)));
    assign fill      = wr_bin_s - rd_bin;
    assign avail     = primed && (fill != '0);
    assign head_skp  = sym_is_skp(head.ctl, head.data);
    assign rd_bin_nx = rd_bin + PTR_W'(1);
    assign raddr     = rd_bin[ADDR_W-1:0];

    always_comb begin
        src = SRC_NONE;
        if (avail) begin
            if ((fill < PTR_W'(LO_MARK)) && last_set_skp && !head_skp
                && (skp_cnt < CNT_W'(MAX_SKP))) begin
                src = SRC_FILL;
            end else begin
                src = SRC_STORE;
            end
        end
    end

    always_comb begin
        sel_ctl  = head.ctl;
        sel_data = head.data;
        if (src == SRC_FILL) begin
            sel_ctl  = 1'b1;
            sel_data = SYM_SKP;
        end
    end

    assign sel_skp = sym_is_skp(sel_ctl, sel_data);
    assign sel_com = sym_is_com(sel_ctl, sel_data);
    assign sel_bad = in_set && ((sel_skp && (skp_cnt == CNT_W'(MAX_SKP)))
                                || (!sel_skp && (skp_cnt == '0)));

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin       <= '0;
            rd_gray      <= '0;
            primed       <= 1'b0;
            underflow    <= 1'b0;
            in_set       <= 1'b0;
            last_set_skp <= 1'b0;
            skp_cnt      <= '0;
            out_valid    <= 1'b0;
            out_ctl      <= 1'b0;
            out_data     <= '0;
            out_ins      <= 1'b0;
            out_del      <= 1'b0;
            out_bad      <= 1'b0;
        end else begin
            if (!primed) begin
                if (fill >= PTR_W'(PRIME_LVL)) begin
                    primed <= 1'b1;
                end
            end else if (fill == '0) begin
                primed    <= 1'b0;
                underflow <= 1'b1;
            end

            if (src == SRC_STORE) begin
                rd_bin  <= rd_bin_nx;
                rd_gray <= PTR_W'(bin_to_gray(GRAY_W'(rd_bin_nx)));
            end

            if (src != SRC_NONE) begin
                if (in_set && sel_skp) begin
                    skp_cnt      <= (skp_cnt == '1) ? skp_cnt : skp_cnt + CNT_W'(1);
                    last_set_skp <= 1'b1;
                end else begin
                    in_set       <= sel_com;
                    skp_cnt      <= '0;
                    last_set_skp <= 1'b0;
                end
            end

            out_valid <= (src != SRC_NONE);
            out_ctl   <= sel_ctl;
            out_data  <= sel_data;
            out_ins   <= (src == SRC_FILL);
            out_del   <= (src == SRC_STORE) && head.del_mark;
            out_bad   <= (src != SRC_NONE) && sel_bad;
        end
    end

endmodule

// File: rtl/skp_rate_match.sv
module skp_rate_match
    import rmf_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int HI_MARK     = 12,
    parameter int LO_MARK     = 4,
    parameter int PRIME_LVL   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       rx_clk,
    input  logic       rx_rst,
    input  logic       rx_valid,
    input  logic       rx_ctl,
    input  logic [7:0] rx_data,
    output logic       rx_overflow,
    input  logic       lc_clk,
    input  logic       lc_rst,
    output logic       lc_valid,
    output logic       lc_ctl,
    output logic [7:0] lc_data,
    output logic       lc_skp_ins,
    output logic       lc_skp_del,
    output logic       lc_bad_set,
    output logic       lc_underflow
);

    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wr_gray, wr_gray_s, rd_gray, rd_gray_s;
    logic              st_we;
    logic [ADDR_W-1:0] st_waddr, st_raddr;
    rmf_word_t         st_wdata, st_rdata;

    rmf_wr_ctl #(
        .ADDR_W  (ADDR_W),
        .HI_MARK (HI_MARK)
    ) u_wr (
        .clk       (rx_clk),
        .rst       (rx_rst),
        .in_valid  (rx_valid),
        .in_ctl    (rx_ctl),
        .in_data   (rx_data),
        .rd_gray_s (rd_gray_s),
        .we        (st_we),
        .waddr     (st_waddr),
        .wdata     (st_wdata),
        .wr_gray   (wr_gray),
        .overflow  (rx_overflow)
    );

    rmf_store #(
        .ADDR_W (ADDR_W)
    ) u_store (
        .wr_clk (rx_clk),
        .we     (st_we),
        .waddr  (st_waddr),
        .wdata  (st_wdata),
        .raddr  (st_raddr),
        .rdata  (st_rdata)
    );

    rmf_sync #(
        .WIDTH  (PTR_W),
        .STAGES (SYNC_STAGES)
    ) u_sync_w2l (
        .clk (lc_clk),
        .rst (lc_rst),
        .d   (wr_gray),
        .q   (wr_gray_s)
    );

    rmf_sync #(
        .WIDTH  (PTR_W),
        .STAGES (SYNC_STAGES)
    ) u_sync_l2w (
        .clk (rx_clk),
        .rst (rx_rst),
        .d   (rd_gray),
        .q   (rd_gray_s)
    );

    rmf_rd_ctl #(
        .ADDR_W    (ADDR_W),
        .LO_MARK   (LO_MARK),
        .PRIME_LVL (PRIME_LVL)
    ) u_rd (
        .clk       (lc_clk),
        .rst       (lc_rst),
        .wr_gray_s (wr_gray_s),
        .raddr     (st_raddr),
        .head      (st_rdata),
        .rd_gray   (rd_gray),
        .out_valid (lc_valid),
        .out_ctl   (lc_ctl),
        .out_data  (lc_data),
        .out_ins   (lc_skp_ins),
        .out_del   (lc_skp_del),
        .out_bad   (lc_bad_set),
        .underflow (lc_underflow)
    );

endmodule

// File: rtl/skp_rate_match_chk.sv
module skp_rate_match_chk
    import rmf_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input logic             rx_clk,
    input logic             rx_rst,
    input logic             rx_overflow,
    input logic             lc_clk,
    input logic             lc_rst,
    input logic             lc_valid,
    input logic             lc_ctl,
    input logic [7:0]       lc_data,
    input logic             lc_skp_ins,
    input logic             lc_skp_del,
    input logic             lc_bad_set,
    input logic             lc_underflow,
    input logic [PTR_W-1:0] wr_gray,
    input logic [PTR_W-1:0] rd_gray
);

    a_r9_ins_del_excl: assert property (@(posedge lc_clk) disable iff (lc_rst)
        !(lc_skp_ins && lc_skp_del));

    a_r9_pulse_has_byte: assert property (@(posedge lc_clk) disable iff (lc_rst)
        (lc_skp_ins || lc_skp_del || lc_bad_set) |-> lc_valid);

    a_r4_ins_is_skp: assert property (@(posedge lc_clk) disable iff (lc_rst)
        lc_skp_ins |-> (lc_ctl && (lc_data == SYM_SKP)));

    a_r6_bad_not_inserted: assert property (@(posedge lc_clk) disable iff (lc_rst)
        lc_bad_set |-> !lc_skp_ins);

    a_r8_underflow_sticky: assert property (@(posedge lc_clk) disable iff (lc_rst)
        lc_underflow |=> lc_underflow);

    a_r7_overflow_sticky: assert property (@(posedge rx_clk) disable iff (rx_rst)
        rx_overflow |=> rx_overflow);

    a_r1_wr_gray_step: assert property (@(posedge rx_clk) disable iff (rx_rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    a_r1_rd_gray_step: assert property (@(posedge lc_clk) disable iff (lc_rst)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

endmodule

bind skp_rate_match skp_rate_match_chk #(.PTR_W(ADDR_W + 1)) u_chk (
    .rx_clk       (rx_clk),
    .rx_rst       (rx_rst),
    .rx_overflow  (rx_overflow),
    .lc_clk       (lc_clk),
    .lc_rst       (lc_rst),
    .lc_valid     (lc_valid),
    .lc_ctl       (lc_ctl),
    .lc_data      (lc_data),
    .lc_skp_ins   (lc_skp_ins),
    .lc_skp_del   (lc_skp_del),
    .lc_bad_set   (lc_bad_set),
    .lc_underflow (lc_underflow),
    .wr_gray      (wr_gray),
    .rd_gray      (rd_gray)
);

// File: tb/skp_rate_match_tb.sv
`timescale 1ns/1ps
module skp_rate_match_tb;

    logic       rx_clk = 1'b0, lc_clk = 1'b0;
    logic       rx_rst, lc_rst;
    logic       rx_valid, rx_ctl;
    logic [7:0] rx_data;
    logic       rx_overflow;
    logic       lc_valid, lc_ctl, lc_skp_ins, lc_skp_del, lc_bad_set, lc_underflow;
    logic [7:0] lc_data;

    real rx_half = 2.0;

    skp_rate_match u_dut (
        .rx_clk(rx_clk), .rx_rst(rx_rst), .rx_valid(rx_valid), .rx_ctl(rx_ctl),
        .rx_data(rx_data), .rx_overflow(rx_overflow),
        .lc_clk(lc_clk), .lc_rst(lc_rst), .lc_valid(lc_valid), .lc_ctl(lc_ctl),
        .lc_data(lc_data), .lc_skp_ins(lc_skp_ins), .lc_skp_del(lc_skp_del),
        .lc_bad_set(lc_bad_set), .lc_underflow(lc_underflow)
    );

    always #2 lc_clk = ~lc_clk;
    initial forever #(rx_half) rx_clk = ~rx_clk;

    int total = 0, bad = 0, cyc = 0;
    int n_ins = 0, n_del = 0, n_bad = 0;
    bit mon_en = 0;

    logic [8:0] exp_q[$];
    int         set_q[$];
    bit         i_in_set = 0;
    int         i_cnt = 0;
    bit         o_in_set = 0;
    int         o_cnt = 0, o_ins = 0, o_del = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge lc_clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    function automatic bit f_skp(input logic c, input logic [7:0] d);
        return c && d == 8'h1C;
    endfunction

    function automatic bit f_com(input logic c, input logic [7:0] d);
        return c && d == 8'hBC;
    endfunction

    // expected malformed flag, from the output stream alone (R6)
    function automatic bit f_bad_exp(input bit in_set, input int cnt, input bit skp);
        return in_set && ((skp && cnt == 5) || (!skp && cnt == 0));
    endfunction

    task automatic close_out_set();
        int in_cnt;
        if (set_q.size() == 0) begin
            chk(1'b0, "R5 set missing", 0, 1);
        end else begin
            in_cnt = set_q.pop_front();
            chk(o_cnt + o_del - o_ins == in_cnt, "R5 balance", o_cnt + o_del - o_ins, in_cnt);
            if (in_cnt >= 1 && in_cnt <= 5)
                chk(o_cnt >= 1 && o_cnt <= 5, "R5 legal", o_cnt, in_cnt);
        end
    endtask

    always @(negedge lc_clk) begin
        if (mon_en) begin
            if (lc_skp_ins || lc_skp_del || lc_bad_set) begin
                chk(!(lc_skp_ins && lc_skp_del), "R9 excl", 1, 0);
                chk(lc_valid, "R9 valid", lc_valid, 1);
            end
            if (lc_valid) begin
                bit skp, com, eb;
                skp = f_skp(lc_ctl, lc_data);
                com = f_com(lc_ctl, lc_data);
                eb  = f_bad_exp(o_in_set, o_cnt, skp);
                chk(lc_bad_set == eb, "R6 bad", lc_bad_set, eb);
                if (lc_bad_set) n_bad++;
                if (lc_skp_del) begin
                    n_del++;
                    chk(o_in_set && o_cnt >= 1, "R3 del", o_cnt, 1);
                    o_del++;
                end
                if (lc_skp_ins) begin
                    n_ins++;
                    chk(o_in_set && skp && o_cnt >= 1 && o_cnt <= 4, "R4 ins", o_cnt, 4);
                    o_ins++;
                end
                if (o_in_set && skp) begin
                    o_cnt++;
                end else begin
                    if (o_in_set) close_out_set();
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R1 extra byte", {lc_ctl, lc_data}, 0);
                    end else begin
                        logic [8:0] t;
                        t = exp_q.pop_front();
                        chk(t == {lc_ctl, lc_data}, (t[7:0] == 8'h1C) ? "R2 stray" : "R1 order",
                            {lc_ctl, lc_data}, t);
                    end
                    o_in_set = com;
                    o_cnt = 0; o_ins = 0; o_del = 0;
                end
            end
        end
    end

    task automatic send(input logic c, input logic [7:0] d);
        @(negedge rx_clk);
        rx_valid = 1'b1; rx_ctl = c; rx_data = d;
        if (i_in_set && f_skp(c, d)) begin
            i_cnt++;
        end else begin
            if (i_in_set) set_q.push_back(i_cnt);
            exp_q.push_back({c, d});
            i_in_set = f_com(c, d);
            i_cnt = 0;
        end
    endtask

    task automatic idle_rx();
        @(negedge rx_clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_data();
        if ($urandom % 10 == 0) send(1'b1, 8'hF7);
        else send(1'b0, 8'($urandom));
    endtask

    task automatic send_set(input int n);
        send(1'b1, 8'hBC);
        for (int k = 0; k < n; k++) send(1'b1, 8'h1C);
    endtask

    task automatic random_groups(input int n);
        for (int g = 0; g < n; g++) begin
            int gap, r, ns;
            gap = 4 + int'($urandom % 6);
            for (int k = 0; k < gap; k++) begin
                send_data();
                if (k == 1 && $urandom % 6 == 0) send(1'b1, 8'h1C);
            end
            r = int'($urandom % 10);
            case (r)
                7: ns = 1 + int'($urandom % 2);
                8: ns = 4 + int'($urandom % 2);
                9: ns = ($urandom % 2 == 0) ? 0 : 7 + int'($urandom % 2);
                default: ns = 3;
            endcase
            send_set(ns);
        end
        send_data();
    endtask

    initial begin
        void'($urandom(32'd4242));
        rx_rst = 1'b1; lc_rst = 1'b1;
        rx_valid = 1'b0; rx_ctl = 1'b0; rx_data = '0;
        repeat (6) @(posedge lc_clk);
        @(negedge lc_clk);
        rx_rst = 1'b0; lc_rst = 1'b0;
        @(negedge lc_clk);
        chk(lc_valid == 1'b0, "R10 valid", lc_valid, 0);
        chk(lc_underflow == 1'b0, "R10 underflow", lc_underflow, 0);
        chk(rx_overflow == 1'b0, "R10 overflow", rx_overflow, 0);
        chk(!(lc_skp_ins || lc_skp_del || lc_bad_set), "R10 pulses", 1, 0);
        mon_en = 1;

        // directed corner cases
        for (int k = 0; k < 10; k++) send_data();
        send_set(3);
        send_data(); send(1'b1, 8'h1C); send_data();   // stray skip (R2)
        send(1'b1, 8'hBC); send(1'b0, 8'h1C);          // empty set closed by data 0x1C (R2, R6)
        send_data();
        send_set(7);                                    // long set (R6)
        send_data(); send_data(); send_set(1); send_data();

        rx_half = 1.925;                                // recovered clock faster
        random_groups(260);
        rx_half = 2.075;                                // recovered clock slower
        random_groups(260);
        for (int k = 0; k < 4; k++) send_data();
        chk(lc_underflow == 1'b0, "R8 no underflow", lc_underflow, 0);
        chk(rx_overflow == 1'b0, "R7 no overflow", rx_overflow, 0);
        idle_rx();
        repeat (300) @(posedge lc_clk);
        @(negedge lc_clk);
        chk(exp_q.size() == 0, "R1 drained", exp_q.size(), 0);
        chk(lc_underflow == 1'b1, "R8 underflow", lc_underflow, 1);
        chk(n_del > 0, "R3 seen", n_del, 1);
        chk(n_ins > 0, "R4 seen", n_ins, 1);
        chk(n_bad > 0, "R6 seen", n_bad, 1);

        // overflow
        mon_en = 0;
        rx_rst = 1'b1; lc_rst = 1'b1;
        repeat (4) @(posedge lc_clk);
        @(negedge lc_clk);
        rx_rst = 1'b0; lc_rst = 1'b0;
        rx_half = 1.0;
        for (int k = 0; k < 80; k++) begin
            @(negedge rx_clk);
            rx_valid = 1'b1; rx_ctl = 1'b0; rx_data = 8'(k);
        end
        idle_rx();
        repeat (10) @(posedge lc_clk);
        @(negedge lc_clk);
        chk(rx_overflow == 1'b1, "R7 overflow", rx_overflow, 1);

        rx_rst = 1'b1; lc_rst = 1'b1;
        repeat (4) @(posedge lc_clk);
        @(negedge lc_clk);
        rx_rst = 1'b0; lc_rst = 1'b0;
        @(negedge lc_clk);
        chk(rx_overflow == 1'b0, "R7 cleared", rx_overflow, 0);
        chk(lc_underflow == 1'b0, "R8 cleared", lc_underflow, 0);
        finish_run();
    end

endmodule